// File: doc/BRIEF.md
# Acquisition Scan List Sequencer

This block keeps an ordered list of conversion entries for a multichannel analog input front end and walks through that list while an acquisition runs. Each entry is 16 bits wide. An entry picks an input channel, a gain code, single-ended or differential input, and two fields for an expansion path. Its start flag says whether the entry waits for a pacer tick or converts as soon as the converter is free. When every entry sets the flag, conversions are evenly paced. When only the first entry sets it, the whole scan bursts after one tick, so the pacer sets the scan rate.

A host loads the list through one 8-bit port, two writes per entry. It then sends an arm pulse. In one-shot mode each arm pulse performs one conversion. In continuous mode the list repeats until a stop pulse arrives. For every conversion the block issues a one-cycle convert strobe and holds the selection outputs. A one-cycle end-of-scan pulse marks the last entry of the list.

Top module: `scan_seq_top`

## Requirements
- R1: An entry is written as two bytes on `wr_byte` with `wr_en`: the low byte first, then the high byte. The entry joins the list only when the high byte arrives, and it is placed after the entries already stored.
- R2: Entry fields: bit 14 is differential, bits 13:12 are gain, bits 10:8 are channel (bit 11 is not used on the internal path), bit 7 is the start flag, bits 5:4 are the expansion gain and bits 3:0 are the expansion channel. The selection outputs take the fields of the converted entry in the same cycle as its convert strobe and keep them until the next strobe. They are zero after reset.
- R3: A `q_reset` pulse empties the list, discards a pending low byte, sends the next conversion to position zero and ends any acquisition in progress.
- R4: An entry whose start flag is 1 waits for `pacer_tick`. Its strobe appears in the cycle after the tick is sampled.
- R5: An entry whose start flag is 0 strobes without a tick. This happens one cycle after arming when it is the first entry, and GAP_CYCLES cycles after the previous strobe otherwise.
- R6: Two convert strobes are always at least GAP_CYCLES cycles apart. A pacer tick that arrives while the converter is busy is dropped.
- R7: After the last stored entry the sequence returns to entry zero. `end_of_scan` pulses for one cycle together with the strobe of that last entry.
- R8: With `continuous` low, one arm pulse performs exactly one conversion. `running` then falls GAP_CYCLES-1 cycles after the strobe, and the next arm pulse continues with the following entry.
- R9: With `continuous` high, conversions repeat until `stop`. `running` falls in the cycle after `stop` is sampled, and no further strobe follows.
- R10: Byte writes while `running` is high are ignored. An arm pulse is ignored while the list is empty.
- R11: The list holds DEPTH entries. An entry completed while the list is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the list port |
| wr_byte | input | 8 | Byte written to the list |
| q_reset | input | 1 | Empty the list and return to idle |
| arm | input | 1 | Start acquisition |
| stop | input | 1 | End acquisition |
| continuous | input | 1 | 1: cycle the list until stopped; 0: one entry per arm |
| pacer_tick | input | 1 | Pacer clock pulse |
| conv_strobe | output | 1 | One-cycle convert command |
| sel_chan | output | 3 | Selected input channel |
| sel_gain | output | 2 | Selected gain code |
| sel_diff | output | 1 | Differential input when 1 |
| sel_xgain | output | 2 | Expansion gain field |
| sel_xchan | output | 4 | Expansion channel field |
| end_of_scan | output | 1 | Pulses with the strobe of the last entry |
| running | output | 1 | Acquisition in progress |

## Verification
The bench builds the block with DEPTH of 8 and GAP_CYCLES of 4. The small depth makes a full list, the ninth write that is dropped and the wrap to entry zero reachable in a few dozen cycles. A gap of 4 leaves room to land a pacer tick inside the busy window and to measure the spacing of a burst. A behavioural model with a queue runs in step with the design and is compared on every clock. Directed checks cover the paced, burst, one-shot, stop, reset and ignored-write cases.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int SEL_CHAN_W = 3;

    // Bit placement matters: the host builds words in this layout.
    typedef struct packed {
        logic       spare15;
        logic       diff;
        logic [1:0] gain;
        logic [3:0] chan;
        logic       start;
        logic       spare6;
        logic [1:0] xgain;
        logic [3:0] xchan;
    } scan_entry_t;

    typedef struct packed {
        logic                  diff;
        logic [1:0]            gain;
        logic [SEL_CHAN_W-1:0] chan;
        logic [1:0]            xgain;
        logic [3:0]            xchan;
    } conv_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BUSY
    } step_state_t;

endpackage

// File: rtl/scan_byte_pack.sv
module scan_byte_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_byte,
    input  logic        lock,
    input  logic        clear,
    output logic        commit,
    output logic [15:0] word
);

    typedef struct packed {
        logic       have_lo;
        logic [7:0] lo;
    } pack_t;

    pack_t pk_d, pk_q;

    always_comb begin
        pk_d   = pk_q;
        commit = 1'b0;
        word   = {wr_byte, pk_q.lo};
        if (clear) begin
            pk_d.have_lo = 1'b0;
        end else if (wr_en && !lock) begin
            if (pk_q.have_lo) begin
                commit       = 1'b1;
                pk_d.have_lo = 1'b0;
            end else begin
                pk_d.have_lo = 1'b1;
                pk_d.lo      = wr_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

endmodule

// File: rtl/scan_list_mem.sv
module scan_list_mem #(
    parameter int DEPTH = 2048,
    parameter int IW    = 11,
    parameter int CW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          commit,
    input  logic [15:0]   word,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_word,
    output logic [CW-1:0] count
);

    logic [15:0]   store [DEPTH];
    logic [CW-1:0] cnt_d, cnt_q;
    logic          full, wr_ok;

    always_comb begin
        full  = (cnt_q == CW'(DEPTH));
        wr_ok = commit && !clear && !full;
        cnt_d = cnt_q;
        if (clear)      cnt_d = '0;
        else if (wr_ok) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) store[cnt_q[IW-1:0]] <= word;
    end

    assign rd_word = store[rd_idx];
    assign count   = cnt_q;

    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    p_full_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && full && !clear) |=> (cnt_q == CW'(DEPTH)));

    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/scan_step_ctrl.sv
module scan_step_ctrl
    import scan_seq_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int GAP_CYCLES = 4,
    parameter int IW         = 11,
    parameter int CW         = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          arm,
    input  logic          stop,
    input  logic          continuous,
    input  logic          pacer_tick,
    input  logic [15:0]   entry_word,
    input  logic [CW-1:0] count,
    output logic [IW-1:0] rd_idx,
    output logic          conv_strobe,
    output logic          end_of_scan,
    output logic          running,
    output conv_sel_t     sel
);

    localparam int GW = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES - 1) : 1;

    typedef struct packed {
        step_state_t   st;
        logic [IW-1:0] rptr;
        logic [GW-1:0] left;
        logic          strobe;
        logic          eos;
        conv_sel_t     sel;
    } ctrl_t;

    ctrl_t       c_d, c_q;
    scan_entry_t ent;
    logic        last;
    logic        unused_bits;

    assign ent         = scan_entry_t'(entry_word);
    assign unused_bits = ^{ent.spare15, ent.spare6, ent.chan[3]};

    always_comb begin
        c_d        = c_q;
        c_d.strobe = 1'b0;
        c_d.eos    = 1'b0;
        last       = (({1'b0, c_q.rptr} + CW'(1)) >= count);
        if (clear) begin
            c_d.st   = ST_IDLE;
            c_d.rptr = '0;
        end else if (stop && c_q.st != ST_IDLE) begin
            c_d.st = ST_IDLE;
        end else begin
            unique case (c_q.st)
                ST_IDLE: begin
                    if (arm && count != '0) c_d.st = ST_WAIT;
                end
                ST_WAIT: begin
                    if (!ent.start || pacer_tick) begin
                        c_d.strobe    = 1'b1;
                        c_d.eos       = last;
                        c_d.sel.diff  = ent.diff;
                        c_d.sel.gain  = ent.gain;
                        c_d.sel.chan  = ent.chan[SEL_CHAN_W-1:0];
                        c_d.sel.xgain = ent.xgain;
                        c_d.sel.xchan = ent.xchan;
                        c_d.rptr      = last ? '0 : c_q.rptr + IW'(1);
                        c_d.left      = GW'(GAP_CYCLES - 2);
                        c_d.st        = ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (c_q.left == '0) c_d.st = continuous ? ST_WAIT : ST_IDLE;
                    else                c_d.left = c_q.left - GW'(1);
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign rd_idx      = c_q.rptr;
    assign conv_strobe = c_q.strobe;
    assign end_of_scan = c_q.eos;
    assign running     = (c_q.st != ST_IDLE);
    assign sel         = c_q.sel;

    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);

    p_eos_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_scan |-> conv_strobe);

    p_strobe_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> running);

    p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && running) |=> !running);

    p_empty_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && arm && count == '0 && !clear) |=> !running);

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int GAP_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       q_reset,
    input  logic       arm,
    input  logic       stop,
    input  logic       continuous,
    input  logic       pacer_tick,
    output logic       conv_strobe,
    output logic [2:0] sel_chan,
    output logic [1:0] sel_gain,
    output logic       sel_diff,
    output logic [1:0] sel_xgain,
    output logic [3:0] sel_xchan,
    output logic       end_of_scan,
    output logic       running
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = IW + 1;

    logic          commit;
    logic [15:0]   commit_word;
    logic [15:0]   rd_word;
    logic [IW-1:0] rd_idx;
    logic [CW-1:0] count;
    conv_sel_t     sel;

    scan_byte_pack u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_byte(wr_byte),
        .lock   (running),
        .clear  (q_reset),
        .commit (commit),
        .word   (commit_word)
    );

    scan_list_mem #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (q_reset),
        .commit (commit),
        .word   (commit_word),
        .rd_idx (rd_idx),
        .rd_word(rd_word),
        .count  (count)
    );

    scan_step_ctrl #(.DEPTH(DEPTH), .GAP_CYCLES(GAP_CYCLES), .IW(IW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (q_reset),
        .arm        (arm),
        .stop       (stop),
        .continuous (continuous),
        .pacer_tick (pacer_tick),
        .entry_word (rd_word),
        .count      (count),
        .rd_idx     (rd_idx),
        .conv_strobe(conv_strobe),
        .end_of_scan(end_of_scan),
        .running    (running),
        .sel        (sel)
    );

    assign sel_chan  = sel.chan;
    assign sel_gain  = sel.gain;
    assign sel_diff  = sel.diff;
    assign sel_xgain = sel.xgain;
    assign sel_xchan = sel.xchan;

endmodule

// File: tb/tb_scan_seq_top.sv
`timescale 1ns/1ps
module tb_scan_seq_top;

    localparam int DEPTH = 8;
    localparam int GAP   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       q_reset = 1'b0, arm = 1'b0, stop = 1'b0, continuous = 1'b0, pacer_tick = 1'b0;
    logic       conv_strobe, sel_diff, end_of_scan, running;
    logic [2:0] sel_chan;
    logic [1:0] sel_gain, sel_xgain;
    logic [3:0] sel_xchan;

    always #2.5 clk = ~clk;

    scan_seq_top #(.DEPTH(DEPTH), .GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .q_reset(q_reset), .arm(arm), .stop(stop), .continuous(continuous),
        .pacer_tick(pacer_tick), .conv_strobe(conv_strobe), .sel_chan(sel_chan),
        .sel_gain(sel_gain), .sel_diff(sel_diff), .sel_xgain(sel_xgain),
        .sel_xchan(sel_xchan), .end_of_scan(end_of_scan), .running(running)
    );

    int  total = 0;
    int  fails = 0;
    bit  done = 0;

    // behavioural reference
    logic [15:0] m_list[$];
    bit          m_have_lo = 0;
    logic [7:0]  m_lo = '0;
    int          m_phase = 0;   // 0 idle, 1 waiting, 2 busy
    int          m_left = 0;
    int          m_pos = 0;
    bit          m_strobe = 0, m_eos = 0;
    logic [15:0] m_cur = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int old_phase = m_phase;
        int sz = m_list.size();
        m_strobe = 0;
        m_eos = 0;
        if (q_reset) begin
            m_list.delete();
            m_have_lo = 0;
            m_phase = 0;
            m_pos = 0;
        end else begin
            if (stop && m_phase != 0) m_phase = 0;
            else if (m_phase == 0) begin
                if (arm && sz > 0) m_phase = 1;
            end else if (m_phase == 1) begin
                if (!m_list[m_pos][7] || pacer_tick) begin
                    m_strobe = 1;
                    m_cur = m_list[m_pos];
                    m_pos++;
                    if (m_pos >= sz) begin m_pos = 0; m_eos = 1; end
                    m_phase = 2;
                    m_left = GAP - 1;
                end
            end else begin
                m_left--;
                if (m_left == 0) m_phase = continuous ? 1 : 0;
            end
            if (wr_en && old_phase == 0) begin
                if (!m_have_lo) begin m_lo = wr_byte; m_have_lo = 1; end
                else begin
                    if (m_list.size() < DEPTH) m_list.push_back({wr_byte, m_lo});
                    m_have_lo = 0;
                end
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(conv_strobe == m_strobe, "R4 strobe vs model", conv_strobe, m_strobe);
        chk(end_of_scan == m_eos, "R7 end_of_scan vs model", end_of_scan, m_eos);
        chk(running == (m_phase != 0), "R8 running vs model", running, m_phase != 0);
        chk(sel_chan == m_cur[10:8] && sel_gain == m_cur[13:12] && sel_diff == m_cur[14]
            && sel_xgain == m_cur[5:4] && sel_xchan == m_cur[3:0], "R2 fields vs model",
            {sel_diff, sel_gain, 1'b0, sel_chan}, {m_cur[14:12], 1'b0, m_cur[10:8]});
    endtask

    function automatic logic [15:0] mk(input bit d, input int g, input int c, input bit s,
                                       input int xg, input int xc);
        return {1'b0, d, 2'(g), 4'(c), s, 1'b0, 2'(xg), 4'(xc)};
    endfunction

    task automatic wr(input logic [7:0] b);
        wr_en = 1; wr_byte = b; tick(); wr_en = 0;
    endtask
    task automatic put(input logic [15:0] w);
        wr(w[7:0]); wr(w[15:8]);
    endtask
    task automatic p_arm();   arm = 1;        tick(); arm = 0;        endtask
    task automatic p_stop();  stop = 1;       tick(); stop = 0;       endtask
    task automatic p_tick();  pacer_tick = 1; tick(); pacer_tick = 0; endtask
    task automatic p_qrst();  q_reset = 1;    tick(); q_reset = 0;    endtask
    task automatic idle(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin tick(); if (conv_strobe) seen++; end
    endtask
    task automatic wait_strobe(output int n);
        n = 0;
        do begin tick(); n++; end while (!conv_strobe && n < 50);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!conv_strobe && !running && !end_of_scan && sel_chan == 0 && sel_xchan == 0,
            "R2 reset state", {running, conv_strobe, sel_chan}, 0);

        // paced list: every entry waits for a tick
        put(mk(0, 1, 2, 1, 3, 5));
        put(mk(1, 2, 5, 1, 0, 9));
        put(mk(0, 3, 7, 1, 2, 0));
        continuous = 1;
        p_arm();
        idle(10, n);
        chk(n == 0, "R4 no strobe without tick", n, 0);
        p_tick();
        chk(conv_strobe && sel_chan == 2 && sel_gain == 1 && sel_xgain == 3 && sel_xchan == 5,
            "R4 strobe after tick with entry0 fields", sel_chan, 2);
        p_tick();
        idle(10, n);
        chk(n == 0, "R6 tick during busy dropped", n, 0);
        p_tick();
        chk(conv_strobe && sel_chan == 5 && sel_diff && sel_xchan == 9, "R2 entry1 fields", sel_chan, 5);
        idle(5, n);
        p_tick();
        chk(conv_strobe && sel_chan == 7 && end_of_scan, "R7 eos on last entry", end_of_scan, 1);
        idle(5, n);
        p_tick();
        chk(conv_strobe && sel_chan == 2 && !end_of_scan, "R7 wrap to entry zero", sel_chan, 2);
        idle(5, n);
        p_stop();
        chk(!running, "R9 stop ends run", running, 0);
        n = 0;
        for (int i = 0; i < 3; i++) begin
            p_tick(); if (conv_strobe) n++;
            tick(); tick();
        end
        chk(n == 0, "R9 no strobe after stop", n, 0);

        // writes while running are ignored
        p_arm();
        put(mk(0, 0, 4, 0, 0, 4));
        p_stop();
        continuous = 0;
        p_arm();
        p_tick();
        chk(conv_strobe && sel_chan == 5, "R8 one-shot continues at entry1", sel_chan, 5);
        idle(GAP - 2, n);
        chk(running, "R8 still busy", running, 1);
        tick();
        chk(!running, "R8 idle after one conversion", running, 0);
        p_tick();
        chk(!conv_strobe, "R8 tick ignored while idle", conv_strobe, 0);
        p_arm(); p_tick();
        chk(conv_strobe && sel_chan == 7 && end_of_scan, "R10 list length unchanged", sel_chan, 7);
        idle(GAP, n);
        p_arm(); p_tick();
        chk(conv_strobe && sel_chan == 2, "R10 ignored entry never appears", sel_chan, 2);
        idle(GAP, n);

        // reset discards lone low byte; burst list
        p_qrst();
        p_arm();
        chk(!running, "R10 arm ignored on empty list", running, 0);
        wr(8'hAB);
        p_qrst();
        put(mk(1, 0, 3, 0, 1, 1));
        put(mk(0, 2, 12, 0, 0, 2));
        put(mk(0, 1, 6, 0, 0, 3));
        put(mk(1, 3, 1, 0, 0, 4));
        continuous = 1;
        p_arm();
        wait_strobe(n);
        chk(n == 1, "R5 first burst strobe one cycle after arm", n, 1);
        chk(sel_chan == 3 && sel_xchan == 1 && sel_diff, "R1 byte order and R3 low byte dropped", sel_xchan, 1);
        wait_strobe(n);
        chk(n == GAP, "R5 burst spacing", n, GAP);
        chk(sel_chan == 4 && sel_gain == 2, "R2 channel bit 11 ignored", sel_chan, 4);
        wait_strobe(n);
        chk(n == GAP, "R6 burst spacing", n, GAP);
        wait_strobe(n);
        chk(end_of_scan && sel_chan == 1, "R7 eos on fourth entry", end_of_scan, 1);
        p_stop();

        // capacity
        p_qrst();
        for (int i = 0; i < DEPTH; i++) put(mk(0, 0, i, 0, 0, 0));
        put(mk(0, 0, 1, 0, 0, 15));
        p_arm();
        for (int i = 0; i < DEPTH; i++) begin
            wait_strobe(n);
            chk(sel_chan == 3'(i) && end_of_scan == (i == DEPTH - 1), "R11 stored order", sel_chan, i);
        end
        wait_strobe(n);
        chk(sel_chan == 0 && sel_xchan == 0, "R11 overflow entry dropped", sel_xchan, 0);
        p_qrst();
        chk(!running, "R3 queue reset ends run", running, 0);
        p_arm();
        chk(!running, "R3 list empty after reset", running, 0);
        idle(4, n);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule